// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the byte-wide register file through which a host programs a four-channel DMA controller. The host reaches it through two 4-bit ports. The channel port holds the 16-bit base and current address and count registers of every channel. The control port holds the command byte, the per-channel mode bytes, a 4-bit mask and an 8-bit status byte, and it decodes a set of one-shot commands. Every 16-bit register moves one byte per access. The low or high byte is picked by a single byte pointer that all channels share.

The transfer engine sits beside this block and takes the mask, request, mode, auto-initialise and current-value outputs from it. It reports terminal count back on `tc_i`, one bit per channel. Reads are combinational from the state before the access. The side effects of an access (pointer toggle, status clear) take effect at the next rising clock edge. Only one port is served per cycle: the channel port wins over the control port, and a write wins over a read.

Top module: `dma_host_regs`

## Requirements
- R1: A channel-port access is `chan_sel_i` with `wr_i` or `rd_i` and `addr_i[3]` = 0. `addr_i[2:1]` selects the channel and `addr_i[0]` selects address (0) or count (1). A write stores `wdata_i` into the low byte of the base register when the byte pointer is 0, and into the high byte when it is 1.
- R2: Every channel-port access, read or write, inverts the byte pointer. A channel read returns the low byte (pointer 0) or the high byte (pointer 1) of the selected current register.
- R3: A high-byte write loads the selected current register with the full new base value in the same edge. A low-byte write leaves the current register unchanged.
- R4: Control offset 2 (single mask) uses `wdata_i[1:0]` as the channel. It sets that channel's mask bit when `wdata_i[2]` = 1 and clears the bit otherwise.
- R5: Control offset 1 (request) uses `wdata_i[1:0]` as the channel. It sets status bit channel+4 when `wdata_i[2]` = 1. Otherwise it clears that bit and also status bit channel. `req_o` equals status bits [7:4].
- R6: Reset and a write to control offset 5 (master clear) both set the byte pointer to 0, the mask to 4'hF, and status and command to 0. Reset also clears the modes and the channel registers; master clear leaves them unchanged.
- R7: Control offset 6 clears all mask bits. Control offset 7 loads the mask from `wdata_i[3:0]`.
- R8: Control offset 3 stores the whole `wdata_i` byte as the mode of channel `wdata_i[1:0]`. `autoinit_o[ch]` is bit 4 of that channel's mode.
- R9: A control read at offset 0 returns the status byte and then clears status bits [3:0], keeping bits [7:4]. A `tc_i` bit sets status bit [ch] at the same edge, and takes precedence over any clear.
- R10: A write to control offset 4 clears the byte pointer and changes nothing else.
- R11: A write to control offset 0 stores `wdata_i` in the command register. A control read at offset 7 returns {4'hF, mask}. A control read at any other offset, and any cycle with no read access, returns 8'hFF.
- R12: An access with `addr_i[3]` = 1 has no effect on any state and reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_sel_i | input | 1 | Selects the channel-register port |
| ctl_sel_i | input | 1 | Selects the control port |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data byte |
| tc_i | input | 4 | Terminal-count pulses from the transfer engine |
| rdata_o | output | 8 | Read data byte |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| autoinit_o | output | 4 | Auto-initialise enable per channel |
| cmd_o | output | 8 | Command register |
| mode_o | output | 32 | Mode bytes, channel n in bits [8n+7:8n] |
| cur_addr_o | output | 64 | Current address, channel n in bits [16n+15:16n] |
| cur_cnt_o | output | 64 | Current count, channel n in bits [16n+15:16n] |

## Verification
The bench targets the shared byte pointer in several ways. It interleaves reads and writes across channels, and it clears the pointer halfway through a 16-bit load. A design whose pointer is per-channel, or that toggles only on writes, would then write bytes into the wrong halves. It checks that a low-byte write leaves the current register alone and a high-byte write reloads it. An early reload would show up as a half-updated current value. It reads status while `tc_i` pulses and clears requests while terminal count is set, which exposes a clear that wipes the request half or drops a fresh terminal count. It also checks that master clear keeps the modes and that upper-half offsets are inert.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = 2;

  typedef enum logic [2:0] {
    CTL_CMD     = 3'd0,
    CTL_REQ     = 3'd1,
    CTL_SMASK   = 3'd2,
    CTL_MODE    = 3'd3,
    CTL_CLRPTR  = 3'd4,
    CTL_MCLR    = 3'd5,
    CTL_CLRMASK = 3'd6,
    CTL_WMASK   = 3'd7
  } ctl_op_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  cnt_sel_i,
  input  logic                  hi_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rd_byte_o,
  output logic [2*DATA_W-1:0]   cur_addr_o,
  output logic [2*DATA_W-1:0]   cur_cnt_o
);
  localparam int unsigned REG_W = 2 * DATA_W;

  logic [1:0][REG_W-1:0] cur_all;

  for (genvar r = 0; r < 2; r++) begin : g_reg
    logic [REG_W-1:0] base_q, cur_q;
    logic             hit;
    assign hit = wr_i && (cnt_sel_i == 1'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        cur_q  <= '0;
      end else if (hit) begin
        if (hi_i) begin
          base_q[REG_W-1:DATA_W] <= wdata_i;
          cur_q                  <= {wdata_i, base_q[DATA_W-1:0]};
        end else begin
          base_q[DATA_W-1:0] <= wdata_i;
        end
      end
    end

    assign cur_all[r] = cur_q;
  end

  assign cur_addr_o = cur_all[0];
  assign cur_cnt_o  = cur_all[1];
  assign rd_byte_o  = hi_i ? cur_all[cnt_sel_i][REG_W-1:DATA_W]
                           : cur_all[cnt_sel_i][DATA_W-1:0];
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  ctl_op_e                    op_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       chan_acc_i,
  input  logic [NUM_CH-1:0]          tc_i,
  output logic                       ptr_o,
  output logic [NUM_CH-1:0]          mask_o,
  output logic [2*NUM_CH-1:0]        status_o,
  output logic [DATA_W-1:0]          cmd_o,
  output logic [NUM_CH*DATA_W-1:0]   mode_o
);
  logic                 ptr_q, ptr_d;
  logic [NUM_CH-1:0]    mask_q, mask_d;
  logic [2*NUM_CH-1:0]  stat_q, stat_d;
  logic [DATA_W-1:0]    cmd_q, cmd_d;
  logic [CH_W-1:0]      ch;
  logic                 mclr;

  assign ch   = wdata_i[CH_W-1:0];
  assign mclr = wr_i && (op_i == CTL_MCLR);

  always_comb begin
    ptr_d  = ptr_q;
    mask_d = mask_q;
    stat_d = stat_q;
    cmd_d  = cmd_q;
    if (chan_acc_i) ptr_d = ~ptr_q;
    if (wr_i) begin
      unique case (op_i)
        CTL_CMD:     cmd_d = wdata_i;
        CTL_REQ: begin
          if (wdata_i[2]) begin
            stat_d[NUM_CH + 32'(ch)] = 1'b1;
          end else begin
            stat_d[NUM_CH + 32'(ch)] = 1'b0;
            stat_d[ch]               = 1'b0;
          end
        end
        CTL_SMASK:   mask_d[ch] = wdata_i[2];
        CTL_MODE:    ;
        CTL_CLRPTR:  ptr_d = 1'b0;
        CTL_MCLR: begin
          ptr_d  = 1'b0;
          mask_d = '1;
          stat_d = '0;
          cmd_d  = '0;
        end
        CTL_CLRMASK: mask_d = '0;
        CTL_WMASK:   mask_d = wdata_i[NUM_CH-1:0];
        default:     ;
      endcase
    end else if (rd_i && (op_i == CTL_CMD)) begin
      stat_d[NUM_CH-1:0] = '0;
    end
    stat_d[NUM_CH-1:0] = stat_d[NUM_CH-1:0] | tc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      mask_q <= '1;
      stat_q <= '0;
      cmd_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      cmd_q  <= cmd_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    logic [DATA_W-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              mode_q <= '0;
      else if (wr_i && (op_i == CTL_MODE) && (ch == CH_W'(c)))  mode_q <= wdata_i;
    end
    assign mode_o[c*DATA_W +: DATA_W] = mode_q;
  end

  assign ptr_o    = ptr_q;
  assign mask_o   = mask_q;
  assign status_o = stat_q;
  assign cmd_o    = cmd_q;

  logic unused_mclr;
  assign unused_mclr = mclr;
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           chan_sel_i,
  input  logic                           ctl_sel_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_CH-1:0]              tc_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_CH-1:0]              mask_o,
  output logic [NUM_CH-1:0]              req_o,
  output logic [NUM_CH-1:0]              autoinit_o,
  output logic [DATA_W-1:0]              cmd_o,
  output logic [NUM_CH*DATA_W-1:0]       mode_o,
  output logic [NUM_CH*2*DATA_W-1:0]     cur_addr_o,
  output logic [NUM_CH*2*DATA_W-1:0]     cur_cnt_o
);
  localparam int unsigned REG_W = 2 * DATA_W;

  logic                       in_range;
  logic                       chan_acc, chan_wr, ctl_wr, ctl_rd;
  logic [CH_W-1:0]            chan_idx;
  logic                       byte_ptr;
  logic [2*NUM_CH-1:0]        status_w;
  ctl_op_e                    op;
  logic [NUM_CH-1:0][DATA_W-1:0] chan_rd;

  assign in_range = ~addr_i[ADDR_W-1];
  assign chan_acc = chan_sel_i && in_range && (wr_i || rd_i);
  assign chan_wr  = chan_acc && wr_i;
  assign chan_idx = addr_i[CH_W:1];
  assign ctl_wr   = !chan_sel_i && ctl_sel_i && in_range && wr_i;
  assign ctl_rd   = !chan_sel_i && ctl_sel_i && in_range && rd_i && !wr_i;
  assign op       = ctl_op_e'(addr_i[2:0]);

  dma_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr),
    .rd_i       (ctl_rd),
    .op_i       (op),
    .wdata_i    (wdata_i),
    .chan_acc_i (chan_acc),
    .tc_i       (tc_i),
    .ptr_o      (byte_ptr),
    .mask_o     (mask_o),
    .status_o   (status_w),
    .cmd_o      (cmd_o),
    .mode_o     (mode_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dma_chan_regs #(.DATA_W(DATA_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (chan_wr && (chan_idx == CH_W'(c))),
      .cnt_sel_i  (addr_i[0]),
      .hi_i       (byte_ptr),
      .wdata_i    (wdata_i),
      .rd_byte_o  (chan_rd[c]),
      .cur_addr_o (cur_addr_o[c*REG_W +: REG_W]),
      .cur_cnt_o  (cur_cnt_o[c*REG_W +: REG_W])
    );
    assign autoinit_o[c] = mode_o[c*DATA_W + 4];
  end

  assign req_o = status_w[2*NUM_CH-1:NUM_CH];

  always_comb begin
    rdata_o = '1;
    if (chan_acc && !wr_i) begin
      rdata_o = chan_rd[chan_idx];
    end else if (ctl_rd) begin
      if (op == CTL_CMD)        rdata_o = status_w;
      else if (op == CTL_WMASK) rdata_o = {{(DATA_W-NUM_CH){1'b1}}, mask_o};
    end
  end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_sel_i,
  input logic       ctl_sel_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [3:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [3:0] tc_i,
  input logic [3:0] mask_o,
  input logic [3:0] req_o,
  input logic [7:0] cmd_o,
  input logic       ptr_i,
  input logic [7:0] status_i
);
  logic c_acc, k_wr, k_rd;
  assign c_acc = chan_sel_i && !addr_i[3] && (wr_i || rd_i);
  assign k_wr  = !chan_sel_i && ctl_sel_i && !addr_i[3] && wr_i;
  assign k_rd  = !chan_sel_i && ctl_sel_i && !addr_i[3] && rd_i && !wr_i;

  // R2
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_acc |=> ptr_i != $past(ptr_i));

  // R10
  clr_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_wr && addr_i[2:0] == 3'd4) |=> !ptr_i);

  // R6
  master_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_wr && addr_i[2:0] == 3'd5) |=> (mask_o == 4'hF && cmd_o == 8'h00 && req_o == 4'h0 && !ptr_i));

  // R7
  write_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_wr && addr_i[2:0] == 3'd7) |=> mask_o == $past(wdata_i[3:0]));

  // R4
  single_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_wr && addr_i[2:0] == 3'd2) |=> mask_o[$past(wdata_i[1:0])] == $past(wdata_i[2]));

  // R9
  status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_rd && addr_i[2:0] == 3'd0 && tc_i == 4'h0) |=>
      (status_i[3:0] == 4'h0 && status_i[7:4] == $past(status_i[7:4])));
endmodule

bind dma_host_regs dma_host_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chan_sel_i (chan_sel_i),
  .ctl_sel_i  (ctl_sel_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tc_i       (tc_i),
  .mask_o     (mask_o),
  .req_o      (req_o),
  .cmd_o      (cmd_o),
  .ptr_i      (byte_ptr),
  .status_i   (status_w)
);

// File: tb/tb_dma_host_regs.sv
`timescale 1ns/1ps
module tb_dma_host_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        chan_sel_i = 0, ctl_sel_i = 0, wr_i = 0, rd_i = 0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [3:0]  tc_i = '0;
  logic [7:0]  rdata_o;
  logic [3:0]  mask_o, req_o, autoinit_o;
  logic [7:0]  cmd_o;
  logic [31:0] mode_o;
  logic [63:0] cur_addr_o, cur_cnt_o;

  always #2.5 clk_i = ~clk_i;

  dma_host_regs dut (.*);

  int n_vec = 0, n_bad = 0;
  string tag = "R6";

  // behavioural model
  int m_ptr, m_mask, m_st, m_cmd;
  int m_mode[4], m_ba[4], m_bc[4], m_ca[4], m_cc[4];

  function automatic void m_reset();
    m_ptr = 0; m_mask = 15; m_st = 0; m_cmd = 0;
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 0; m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
    end
  endfunction

  function automatic int m_read(bit cs, bit ks, bit w, bit r, int a);
    int ch, v;
    if (cs && (a & 8) == 0 && r && !w) begin
      ch = (a >> 1) & 3;
      v = (a & 1) ? m_cc[ch] : m_ca[ch];
      return m_ptr ? (v >> 8) & 255 : v & 255;
    end
    if (!cs && ks && (a & 8) == 0 && r && !w) begin
      if ((a & 7) == 0) return m_st;
      if ((a & 7) == 7) return 240 | m_mask;
    end
    return 255;
  endfunction

  function automatic void m_step(bit cs, bit ks, bit w, bit r, int a, int d, int tc);
    int ch;
    if (cs && (a & 8) == 0 && (w || r)) begin
      if (w) begin
        ch = (a >> 1) & 3;
        if (a & 1) begin
          if (m_ptr) begin m_bc[ch] = (m_bc[ch] & 255) | (d << 8); m_cc[ch] = m_bc[ch]; end
          else m_bc[ch] = (m_bc[ch] & 65280) | d;
        end else begin
          if (m_ptr) begin m_ba[ch] = (m_ba[ch] & 255) | (d << 8); m_ca[ch] = m_ba[ch]; end
          else m_ba[ch] = (m_ba[ch] & 65280) | d;
        end
      end
      m_ptr = 1 - m_ptr;
    end else if (!cs && ks && (a & 8) == 0 && w) begin
      ch = d & 3;
      case (a & 7)
        0: m_cmd = d;
        1: if (d & 4) m_st = m_st | (1 << (ch + 4));
           else m_st = m_st & ~((1 << (ch + 4)) | (1 << ch));
        2: if (d & 4) m_mask = m_mask | (1 << ch); else m_mask = m_mask & ~(1 << ch);
        3: m_mode[ch] = d;
        4: m_ptr = 0;
        5: begin m_ptr = 0; m_mask = 15; m_st = 0; m_cmd = 0; end
        6: m_mask = 0;
        default: m_mask = d & 15;
      endcase
    end else if (!cs && ks && (a & 8) == 0 && r && (a & 7) == 0) begin
      m_st = m_st & 240;
    end
    m_st = (m_st | tc) & 255;
    m_mask = m_mask & 15;
  endfunction

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_state();
    logic [31:0] em; logic [63:0] ea, ec; logic [3:0] eai;
    for (int i = 0; i < 4; i++) begin
      em[i*8 +: 8]   = 8'(m_mode[i]);
      ea[i*16 +: 16] = 16'(m_ca[i]);
      ec[i*16 +: 16] = 16'(m_cc[i]);
      eai[i]         = m_mode[i][4];
    end
    cmp("mask", 64'(mask_o), 64'(m_mask));
    cmp("req", 64'(req_o), 64'((m_st >> 4) & 15));
    cmp("cmd", 64'(cmd_o), 64'(m_cmd));
    cmp("mode", 64'(mode_o), 64'(em));
    cmp("autoinit", 64'(autoinit_o), 64'(eai));
    cmp("cur_addr", cur_addr_o, ea);
    cmp("cur_cnt", cur_cnt_o, ec);
  endtask

  task automatic cyc(bit cs, bit ks, bit w, bit r, int a, int d, int tc);
    chan_sel_i = cs; ctl_sel_i = ks; wr_i = w; rd_i = r;
    addr_i = 4'(a); wdata_i = 8'(d); tc_i = 4'(tc);
    #1;
    cmp("rdata", 64'(rdata_o), 64'(m_read(cs, ks, w, r, a)));
    @(posedge clk_i);
    m_step(cs, ks, w, r, a, d, tc);
    @(negedge clk_i);
    cmp_state();
  endtask

  task automatic cw(int a, int d);  cyc(1, 0, 1, 0, a, d, 0); endtask
  task automatic cr(int a);         cyc(1, 0, 0, 1, a, 0, 0); endtask
  task automatic kw(int a, int d);  cyc(0, 1, 1, 0, a, d, 0); endtask
  task automatic kr(int a);         cyc(0, 1, 0, 1, a, 0, 0); endtask
  task automatic idle(int tc);      cyc(0, 0, 0, 0, 0, 0, tc); endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_reset();
    @(negedge clk_i); @(negedge clk_i);
    tag = "R6";  // reset state
    cmp_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    kr(0); kr(7);

    tag = "R1";
    cw(0, 8'h34); cw(0, 8'h12);
    cw(5, 8'hCD); cw(5, 8'hAB);
    cw(7, 8'h01); cw(7, 8'h80);

    tag = "R3";
    cw(2, 8'h55);                 // low byte only: current keeps 0
    cw(2, 8'h66);                 // high byte reload
    cw(2, 8'h77);                 // low byte again: current holds
    cw(3, 8'h99);                 // ptr is 1 here, so high byte of ch1 count

    tag = "R2";
    cr(0); cr(0); cr(5); cr(4); cr(7); cr(7);
    cw(6, 8'hEE); cr(6); cr(6);

    tag = "R10";
    cw(4, 8'h11); kw(4, 0); cw(4, 8'h22); cw(4, 8'h33); cr(4); cr(4);

    tag = "R4";
    kw(6, 0);
    kw(2, 4 | 2); kw(2, 4 | 0); kr(7); kw(2, 0 | 2); kr(7); kw(2, 8'hF8 | 3);

    tag = "R7";
    kw(7, 8'hA5); kr(7); kw(6, 8'hFF); kr(7); kw(7, 8'h0C);

    tag = "R8";
    kw(3, 8'h10); kw(3, 8'h53); kw(3, 8'hE6); kw(3, 8'h01);

    tag = "R5";
    kw(1, 4 | 1); kw(1, 4 | 3);
    idle(4'b0010); kr(0);
    idle(4'b1010);
    kw(1, 0 | 1); kr(0); kw(1, 3);

    tag = "R9";
    kw(1, 4 | 2); idle(4'b0101); kr(0); kr(0);
    idle(4'b1000); cyc(0, 1, 0, 1, 0, 0, 4'b0001); kr(0);

    tag = "R11";
    kw(0, 8'hC3); kr(0); for (int o = 1; o < 7; o++) kr(o);
    idle(0); kw(0, 8'h3C);

    tag = "R12";
    cw(8, 8'h42); cw(13, 8'h42); cr(9); kw(13, 0); kw(10, 0); kw(8, 8'hFF); kr(8); kr(15);
    cw(0, 8'h01);

    tag = "R6";
    kw(1, 4 | 0); idle(4'b0011);
    kw(5, 0); kr(7); kr(0); cw(0, 8'h5A); cr(0);

    tag = "R1";
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      int a = $urandom_range(0, 15);
      int d = $urandom_range(0, 255);
      int tc = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0;
      if (a >= 8 && $urandom_range(0, 3) != 0) a = a - 8;
      case (sel)
        0, 1, 2: cyc(1, 0, 1, 0, a, d, tc);
        3, 4:    cyc(1, 0, 0, 1, a, d, tc);
        5, 6:    cyc(0, 1, 1, 0, a, d, tc);
        7, 8:    cyc(0, 1, 0, 1, a, d, tc);
        default: cyc($urandom_range(0, 1), 1, 1, 1, a, d, tc);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule